// File: doc/BRIEF.md
# GPIO Expander Register Bank

An eight-pin general-purpose I/O register bank that sits behind a byte-wide register bus, normally driven by a serial slave front end. A byte pointer selects a register. A one-cycle write strobe loads the byte on the write-data bus into the selected register. A one-cycle read strobe loads the selected value into a read-data register, which then stays constant while the front end shifts it out.

Four registers can be written: the output latch, a polarity mask, a direction mask and a timeout-control byte. The input view is read-only. It returns the synchronised pin levels, with bits inverted where the polarity mask is set and the pin is an input. The bank drives a per-pin output enable and output value. Open-drain pins, chosen by a parameter mask (pin 0 by default), can only pull low or release. Bit 0 of the timeout byte is brought out as an enable for the bus-timeout logic of the serial front end. The bank has two resets: an asynchronous power-on reset and a synchronous active-low external reset. Either one returns every register to its default, which turns all pins back into inputs.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, reads at pointer 0x01 return 0x00, at 0x02 return 0xF0, at 0x03 return 0xFF and at 0x04 return 0x01, and every output enable is low.
- R2: A write strobe at pointer 0x01, 0x02, 0x03 or 0x04 stores the whole write-data byte, and a later read at the same pointer returns it.
- R3: A write at pointer 0x00 changes no register and no pin output.
- R4: A read at pointer 0x00 returns pin_i XOR (polarity AND direction). A polarity bit therefore inverts only pins whose direction bit is 1 (input). Pins configured as outputs are still reported at their pin level.
- R5: Direction bit 1 turns the pin's output enable off. For a push-pull pin, direction bit 0 turns the output enable on and drives the output-latch bit.
- R6: An open-drain pin (bit set in OD_MASK, default 0x01) always has pin_out_o 0. Its enable is on only when its direction bit is 0 and its output-latch bit is 0.
- R7: A read at pointer 0x01 returns the output latch, whatever level the pins show.
- R8: rdata_o changes only on a clock edge where rd_i is high, and holds its value between read strobes.
- R9: A read at a pointer above 0x04 returns 0x00. A write at such a pointer changes no register and no pin output.
- R10: A write to the output latch or the direction register is visible on the pin outputs from the clock edge that samples the write strobe. The outputs do not change before that edge.
- R11: External reset low at a clock edge returns every register to its R1 default, so all output enables are low after that edge.
- R12: tmo_en_o equals bit 0 of the timeout register (pointer 0x04).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_ni | input | 1 | Synchronous external reset, active low |
| ptr_i | input | 8 | Register pointer |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, captured on read strobe |
| pin_i | input | 8 | Synchronised pin levels |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_out_o | output | 8 | Per-pin output value |
| tmo_en_o | output | 1 | Bus-timeout enable for the serial front end |

## Verification
The bench targets four mistakes:
- Inverting an output-configured pin. A design that applied the polarity mask to every pin would return inverted bits for outputs when the input view is read.
- Driving the open-drain pin high. A design that treated pin 0 as push-pull would raise its output value, or keep its enable on, when its latch bit is 1.
- Reading the output register from the pins. With the pins held at a different level, a design that read back pin levels instead of the latch would return the wrong byte.
- Leaking writes. Writes to the input view or to unmapped pointers are followed by reads of the other registers and a look at the pins, so a design that decoded too few pointer bits would corrupt them.

The bench also checks that read data stays constant when the pins change between strobes, and that the external reset restores every default.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  typedef enum logic [7:0] {
    PTR_IN  = 8'h00,
    PTR_OUT = 8'h01,
    PTR_POL = 8'h02,
    PTR_DIR = 8'h03,
    PTR_TMO = 8'h04
  } ptr_e;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] RST_OUT = 8'h00;
  localparam logic [BYTE_W-1:0] RST_POL = 8'hF0;
  localparam logic [BYTE_W-1:0] RST_DIR = 8'hFF;
  localparam logic [BYTE_W-1:0] RST_TMO = 8'h01;

  typedef struct packed {
    logic [BYTE_W-1:0] out_q;
    logic [BYTE_W-1:0] pol_q;
    logic [BYTE_W-1:0] dir_q;
    logic [BYTE_W-1:0] tmo_q;
  } regs_t;
endpackage

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_ni,
  input  logic [BYTE_W-1:0] ptr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output regs_t             regs_o
);
  localparam regs_t RST_REGS = '{out_q: RST_OUT, pol_q: RST_POL,
                                 dir_q: RST_DIR, tmo_q: RST_TMO};
  regs_t regs_q, regs_d;

  always_comb begin
    regs_d = regs_q;
    if (!ext_rst_ni) begin
      regs_d = RST_REGS;
    end else if (wr_i) begin
      unique case (ptr_i)
        PTR_OUT: regs_d.out_q = wdata_i;
        PTR_POL: regs_d.pol_q = wdata_i;
        PTR_DIR: regs_d.dir_q = wdata_i;
        PTR_TMO: regs_d.tmo_q = wdata_i;
        default: ;  // input view and unmapped pointers: no effect
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= RST_REGS;
    else         regs_q <= regs_d;
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] ptr_i,
  input  logic [BYTE_W-1:0] pin_i,
  input  regs_t             regs_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] sel, in_view, rdata_q;

  // polarity acts only where the pin is an input
  assign in_view = pin_i ^ (regs_i.pol_q & regs_i.dir_q);

  always_comb begin
    unique case (ptr_i)
      PTR_IN:  sel = in_view;
      PTR_OUT: sel = regs_i.out_q;
      PTR_POL: sel = regs_i.pol_q;
      PTR_DIR: sel = regs_i.dir_q;
      PTR_TMO: sel = regs_i.tmo_q;
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= sel;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int               W       = 8,
  parameter logic [W-1:0]     OD_MASK = 'h1
) (
  input  logic [W-1:0] out_i,
  input  logic [W-1:0] dir_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] val_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (OD_MASK[i]) begin : g_od
      assign oe_o[i]  = ~dir_i[i] & ~out_i[i];
      assign val_o[i] = 1'b0;
    end else begin : g_pp
      assign oe_o[i]  = ~dir_i[i];
      assign val_o[i] = out_i[i];
    end
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OD_MASK = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_ni,
  input  logic [BYTE_W-1:0] ptr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] pin_oe_o,
  output logic [BYTE_W-1:0] pin_out_o,
  output logic              tmo_en_o
);
  regs_t regs;

  gpio_reg_file u_regs (
    .clk_i, .rst_ni, .ext_rst_ni, .ptr_i, .wr_i, .wdata_i,
    .regs_o(regs)
  );

  gpio_read_mux u_rmux (
    .clk_i, .rst_ni, .rd_i, .ptr_i, .pin_i,
    .regs_i(regs), .rdata_o
  );

  gpio_pin_drive #(.W(BYTE_W), .OD_MASK(OD_MASK)) u_drive (
    .out_i(regs.out_q), .dir_i(regs.dir_q),
    .oe_o(pin_oe_o), .val_o(pin_out_o)
  );

  assign tmo_en_o = regs.tmo_q[0];
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int           W       = 8,
  parameter logic [W-1:0] OD_MASK = 'h1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ext_rst_ni,
  input logic [W-1:0] ptr_i,
  input logic         wr_i,
  input logic [W-1:0] wdata_i,
  input logic         rd_i,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] pin_oe_o,
  input logic [W-1:0] pin_out_o,
  input logic         tmo_en_o
);
  // R6
  od_low_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & OD_MASK) == '0);

  // R11
  ext_rst_inputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_ni |=> (pin_oe_o == '0) && tmo_en_o);

  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R10
  out_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_ni && wr_i && ptr_i == 8'h01 |=>
      (pin_out_o & ~OD_MASK) == ($past(wdata_i) & ~OD_MASK));

  // R5
  dir_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_ni && wr_i && ptr_i == 8'h03 |=>
      (pin_oe_o & ~OD_MASK) == (~$past(wdata_i) & ~OD_MASK));

  // R9
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_ni && wr_i && ptr_i > 8'h04 |=>
      $stable(pin_oe_o) && $stable(pin_out_o) && $stable(tmo_en_o));

  // R12
  tmo_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_ni && wr_i && ptr_i == 8'h04 |=> tmo_en_o == $past(wdata_i[0]));
endmodule

bind gpio_regbank gpio_regbank_chk #(.W(8), .OD_MASK(OD_MASK)) u_chk (
  .clk_i, .rst_ni, .ext_rst_ni, .ptr_i, .wr_i, .wdata_i, .rd_i,
  .rdata_o, .pin_oe_o, .pin_out_o, .tmo_en_o
);

// File: tb/gpio_regbank_test.sv
module gpio_regbank_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_rst_ni = 1'b1;
  logic [7:0] ptr_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic [7:0] pin_i = '0;
  logic [7:0] pin_oe_o, pin_out_o;
  logic       tmo_en_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];
  event       rd_done;

  always #2 clk = ~clk;

  gpio_regbank uut (
    .clk_i(clk), .rst_ni, .ext_rst_ni, .ptr_i, .wr_i, .wdata_i,
    .rd_i, .rdata_o, .pin_i, .pin_oe_o, .pin_out_o, .tmo_en_o
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the expected read items and compares them
  initial forever begin
    @(rd_done);
    check(req_q.pop_front(), rdata_o, exp_q.pop_front());
  end

  task automatic do_read(logic [7:0] p, logic [7:0] exp, string req);
    @(negedge clk); ptr_i = p; rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
    exp_q.push_back(exp); req_q.push_back(req);
    -> rd_done;
    #0;
  endtask

  task automatic do_write(logic [7:0] p, logic [7:0] d);
    @(negedge clk); ptr_i = p; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    pin_i = 8'hA5;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 oe", pin_oe_o, 8'h00);
    check("R12 tmo_en", {7'b0, tmo_en_o}, 8'h01);
    do_read(8'h01, 8'h00, "R1 out");
    do_read(8'h02, 8'hF0, "R1 pol");
    do_read(8'h03, 8'hFF, "R1 dir");
    do_read(8'h04, 8'h01, "R1 tmo");
    // R4 default polarity on all-input pins
    do_read(8'h00, 8'hA5 ^ 8'hF0, "R4 in default");
    // R2 / R10 output latch write
    @(negedge clk); ptr_i = 8'h01; wdata_i = 8'h5A; wr_i = 1'b1;
    #1 check("R10 before edge", pin_out_o, 8'h00);
    @(negedge clk); wr_i = 1'b0;
    check("R10 after edge", pin_out_o, 8'h5A & 8'hFE);
    do_write(8'h02, 8'h3C);
    do_read(8'h02, 8'h3C, "R2 pol");
    do_write(8'h03, 8'h0F);
    do_read(8'h03, 8'h0F, "R2 dir");
    check("R5 oe half", pin_oe_o, 8'hF0);
    // R4 polarity only on inputs: mask 3C & 0F = 0C
    do_read(8'h00, 8'hA5 ^ 8'h0C, "R4 in mixed");
    do_write(8'h03, 8'h00);
    check("R6 oe od low", pin_oe_o, 8'hFF);
    do_write(8'h01, 8'h5B);
    check("R6 oe od released", pin_oe_o, 8'hFE);
    check("R6 od value", pin_out_o, 8'h5A);
    // R7 latch readback, pins differ
    pin_i = 8'h00;
    do_read(8'h01, 8'h5B, "R7 out latch");
    do_read(8'h00, 8'h00, "R4 in all outputs");
    // R3 write to input view ignored
    do_write(8'h00, 8'hFF);
    check("R3 pins", pin_out_o, 8'h5A);
    do_read(8'h01, 8'h5B, "R3 out kept");
    do_read(8'h03, 8'h00, "R3 dir kept");
    // R9 unmapped pointers
    do_write(8'h07, 8'hFF);
    do_write(8'hFF, 8'hFF);
    check("R9 oe", pin_oe_o, 8'hFE);
    check("R9 out", pin_out_o, 8'h5A);
    do_read(8'h07, 8'h00, "R9 read 07");
    do_read(8'hFF, 8'h00, "R9 read FF");
    do_read(8'h02, 8'h3C, "R9 pol kept");
    // R8 read data holds between strobes
    pin_i = 8'h11;
    do_read(8'h00, 8'h11, "R8 capture");
    pin_i = 8'hEE;
    repeat (3) @(negedge clk);
    check("R8 hold", rdata_o, 8'h11);
    // R12 timeout enable
    do_write(8'h04, 8'hFE);
    check("R12 tmo off", {7'b0, tmo_en_o}, 8'h00);
    do_read(8'h04, 8'hFE, "R2 tmo");
    // R11 external reset
    @(negedge clk); ext_rst_ni = 1'b0;
    @(negedge clk); ext_rst_ni = 1'b1;
    check("R11 oe", pin_oe_o, 8'h00);
    check("R11 tmo_en", {7'b0, tmo_en_o}, 8'h01);
    do_read(8'h01, 8'h00, "R11 out");
    do_read(8'h02, 8'hF0, "R11 pol");
    do_read(8'h03, 8'hFF, "R11 dir");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule